// File: doc/BRIEF.md
# Drift-Compensated Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day value for precision time synchronisation. A single-cycle `tick` strobe marks each edge of the timing reference. On every enabled tick a 32-bit frequency-trim word is summed into a 32-bit fractional accumulator. Whenever that sum overflows, the counter moves forward by a programmable nanosecond step. In bypass mode the accumulator is skipped and the counter moves forward by the step on every enabled tick.

Software reaches the block through a small synchronous register port with 32-bit data. Reads and writes of the 64-bit counter take two word accesses, low word first. Reading the low word captures the high half in a shadow register, so the next high-word read returns a value from the same instant. A low-word write is parked in a holding register, and the following high-word write loads all 64 bits on one clock edge. A soft-reset command clears the time state and leaves the configuration alone.

Register map (word address on `addr`): 0 control, 1 trim word, 2 accumulator (read-only), 3 counter low, 4 counter high. Any other address reads as zero and ignores writes.

Top module: `tod_counter`

## Requirements
- R1: After reset, the control word, the trim word, the accumulator and both counter halves all read as zero, and `rdata` is zero.
- R2: While control bit 2 (enable) is 0, ticks change neither the counter nor the accumulator.
- R3: With enable set and bypass clear, each tick sets {carry, accumulator} = accumulator + trim word, with the sum taken modulo 2^32. The counter advances by the step field (control bits 25:16, unsigned nanoseconds) exactly on the ticks where carry is 1.
- R4: With enable set and control bit 3 (bypass) set, each tick advances the counter by the step field, and the accumulator keeps its value.
- R5: In cycles without a tick, and without a counter write or soft reset, the counter and the accumulator hold their values.
- R6: A read of the low word (address 3) returns the counter's low half and captures its high half. A later read of the high word (address 4) returns the captured half, even if the counter has advanced in between.
- R7: A write to the low word leaves the counter unchanged. The next write to the high word loads {high data, held low data} into the counter on that clock edge, and this load takes precedence over a tick in the same cycle.
- R8: Writing control with bit 5 set clears the counter, the accumulator, the shadow and the holding register. The step, bypass and enable fields take the written values, and bit 5 always reads back as 0.
- R9: A new trim word is used from the first tick after the write.
- R10: The counter wraps modulo 2^64.
- R11: `rdata` updates on the clock edge that samples `rd_en`, and it keeps its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle strobe per timing-reference period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |

## Verification
A corrupted accumulator shows at the ports only through the counter. The counter steps on the wrong ticks, so the error can take many ticks to appear when the trim word is small. For that reason the bench also reads the accumulator directly and compares it with a model after every few operations. A stale shadow or holding register is visible at the very next high-word access, as a high half or a loaded value that belongs to another instant. A wrong step or bypass path makes the counter diverge by a whole period within one tick.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int BUS_W    = 32;
  localparam int CNT_W    = 2 * BUS_W;
  localparam int ACC_W    = BUS_W;
  localparam int PER_W    = 10;
  localparam int PER_LSB  = 16;
  localparam int EN_BIT   = 2;
  localparam int BYP_BIT  = 3;
  localparam int SRST_BIT = 5;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_TRIM   = 3'd1,
    A_ACCUM  = 3'd2,
    A_CNT_LO = 3'd3,
    A_CNT_HI = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic             bypass;
    logic             enable;
  } ctrl_t;
endpackage

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic [ACC_W-1:0] trim,
  output logic [ACC_W-1:0] acc,
  output logic             carry
);
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_d, acc_q;
  logic             acc_ce;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, trim};
    acc_ce = adv || clr;
    acc_d  = clr ? '0 : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  assign acc   = acc_q;
  assign carry = sum[ACC_W];

  // R2 R4 R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/tod_count.sv
module tod_count #(
  parameter int CNT_W = 64,
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [PER_W-1:0] period,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam int PAD_W = CNT_W - PER_W;

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = step || load || clr;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else           cnt_d = cnt_q + {{PAD_W{1'b0}}, period};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load && !clr) |=> $stable(cnt_q));

  // R8
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ACC_W-1:0]  acc,
  output ctrl_t             ctrl,
  output logic [ACC_W-1:0]  trim,
  output logic              soft_clr,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [BUS_W-1:0]  rdata
);
  ctrl_t            ctrl_d, ctrl_q;
  logic [ACC_W-1:0] trim_q;
  logic [BUS_W-1:0] hold_d, hold_q;
  logic [BUS_W-1:0] shadow_d, shadow_q;
  logic [BUS_W-1:0] rsel, rdata_q, ctrl_word;
  logic             wr_ctrl, wr_trim, wr_lo, wr_hi, rd_lo;
  logic             hold_ce, shadow_ce;

  always_comb begin
    wr_ctrl  = wr_en && (addr == A_CTRL);
    wr_trim  = wr_en && (addr == A_TRIM);
    wr_lo    = wr_en && (addr == A_CNT_LO);
    wr_hi    = wr_en && (addr == A_CNT_HI);
    rd_lo    = rd_en && (addr == A_CNT_LO);
    soft_clr = wr_ctrl && wdata[SRST_BIT];
    load     = wr_hi;
    load_val = {wdata, hold_q};

    ctrl_d.period = wdata[PER_LSB +: PER_W];
    ctrl_d.bypass = wdata[BYP_BIT];
    ctrl_d.enable = wdata[EN_BIT];

    hold_ce   = wr_lo || soft_clr;
    hold_d    = soft_clr ? '0 : wdata;
    shadow_ce = rd_lo || soft_clr;
    shadow_d  = soft_clr ? '0 : cnt[CNT_W-1:BUS_W];

    ctrl_word                   = '0;
    ctrl_word[PER_LSB +: PER_W] = ctrl_q.period;
    ctrl_word[BYP_BIT]          = ctrl_q.bypass;
    ctrl_word[EN_BIT]           = ctrl_q.enable;

    case (addr)
      A_CTRL:   rsel = ctrl_word;
      A_TRIM:   rsel = trim_q;
      A_ACCUM:  rsel = acc;
      A_CNT_LO: rsel = cnt[BUS_W-1:0];
      A_CNT_HI: rsel = shadow_q;
      default:  rsel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trim_q <= '0;
    else if (wr_trim) trim_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_ce) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_ce) shadow_q <= shadow_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rsel;
  end

  assign ctrl  = ctrl_q;
  assign trim  = trim_q;
  assign rdata = rdata_q;

  // R6
  shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !soft_clr) |=> (shadow_q == $past(cnt[CNT_W-1:BUS_W])));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata
);
  logic [1:0]       rs_q;
  logic             rst_ns;
  ctrl_t            ctrl;
  logic [ACC_W-1:0] trim, acc;
  logic [CNT_W-1:0] cnt, load_val;
  logic             soft_clr, load, carry, adv, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  always_comb begin
    adv  = tick && ctrl.enable && !ctrl.bypass;
    step = tick && ctrl.enable && (ctrl.bypass || carry);
  end

  tod_regs i_regs (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .acc(acc), .ctrl(ctrl), .trim(trim),
    .soft_clr(soft_clr), .load(load), .load_val(load_val), .rdata(rdata)
  );

  tod_accum #(.ACC_W(ACC_W)) i_accum (
    .clk(clk), .rst_n(rst_ns), .adv(adv), .clr(soft_clr), .trim(trim),
    .acc(acc), .carry(carry)
  );

  tod_count #(.CNT_W(CNT_W), .PER_W(PER_W)) i_count (
    .clk(clk), .rst_n(rst_ns), .step(step), .period(ctrl.period),
    .load(load), .load_val(load_val), .clr(soft_clr), .cnt(cnt)
  );

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ctrl.enable && !load && !soft_clr) |=> $stable(cnt));

  // R4
  bypass_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (tick && ctrl.enable && ctrl.bypass && !load && !soft_clr)
    |=> ((cnt - $past(cnt)) == {{(CNT_W-PER_W){1'b0}}, $past(ctrl.period)}));

  // R7
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && addr == A_CNT_HI && !soft_clr)
    |=> (cnt[CNT_W-1:BUS_W] == $past(wdata)));

  // R8
  soft_clr_acc_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    soft_clr |=> (acc == '0));
endmodule

// File: tb/test_tod_counter.sv
`timescale 1ns/1ps
module test_tod_counter;
  localparam logic [2:0] AC = 3'd0, AT = 3'd1, AA = 3'd2, AL = 3'd3, AH = 3'd4;

  logic clk, rst_n, tick, wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;

  int n_cmp, n_bad;
  bit done;

  logic [63:0] m_cnt;
  logic [31:0] m_acc, m_trim, m_hold, m_shadow, m_rd;
  logic [9:0]  m_per;
  logic        m_en, m_byp;

  tod_counter i_tod_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [32:0] acc_sum(input logic [31:0] a, input logic [31:0] t);
    return {1'b0, a} + {1'b0, t};
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [9:0] p, input logic b, input logic e);
    logic [31:0] w;
    w = '0;
    w[25:16] = p;
    w[3] = b;
    w[2] = e;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic t, input logic we, input logic re,
                      input logic [2:0] a, input logic [31:0] d);
    logic [32:0] s;
    logic [63:0] o_cnt;
    logic [31:0] o_acc;
    @(negedge clk);
    tick = t; wr_en = we; rd_en = re; addr = a; wdata = d;
    @(posedge clk);
    o_cnt = m_cnt;
    o_acc = m_acc;
    s = acc_sum(o_acc, m_trim);
    if (re) begin
      case (a)
        AC: m_rd = ctrl_word(m_per, m_byp, m_en);
        AT: m_rd = m_trim;
        AA: m_rd = o_acc;
        AL: begin m_rd = o_cnt[31:0]; m_shadow = o_cnt[63:32]; end
        AH: m_rd = m_shadow;
        default: m_rd = '0;
      endcase
    end
    if (t && m_en) begin
      if (m_byp) m_cnt = o_cnt + {54'd0, m_per};
      else begin
        m_acc = s[31:0];
        if (s[32]) m_cnt = o_cnt + {54'd0, m_per};
      end
    end
    if (we) begin
      case (a)
        AC: begin
          m_per = d[25:16]; m_byp = d[3]; m_en = d[2];
          if (d[5]) begin
            m_cnt = '0; m_acc = '0; m_hold = '0; m_shadow = '0;
          end
        end
        AT: m_trim = d;
        AL: m_hold = d;
        AH: m_cnt = {d, m_hold};
        default: ;
      endcase
    end
  endtask

  task automatic idle_inputs();
    tick = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(0, 1, 0, a, d);
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    step(0, 0, 1, a, 0);
    @(negedge clk);
    idle_inputs();
    chk(tag, {32'd0, rdata}, {32'd0, m_rd});
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1, 0, 0, '0, 0);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] r;
    logic [31:0] last;
    n_cmp = 0; n_bad = 0;
    m_cnt = '0; m_acc = '0; m_trim = '0; m_hold = '0; m_shadow = '0; m_rd = '0;
    m_per = '0; m_en = 0; m_byp = 0;
    seed = $urandom(32'd20240611);
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 rdata at reset", {32'd0, rdata}, 64'd0);
    rd_chk(AC, "R1 ctrl");
    rd_chk(AT, "R1 trim");
    rd_chk(AA, "R1 accum");
    rd_chk(AL, "R1 cnt lo");
    rd_chk(AH, "R1 cnt hi");

    // R2: disabled ticks do nothing
    wr(AT, 32'h4000_0000);
    wr(AC, ctrl_word(10'd8, 1'b0, 1'b0));
    ticks(6);
    rd_chk(AL, "R2 cnt lo disabled");
    rd_chk(AA, "R2 accum disabled");

    // R3: half-rate carry
    wr(AT, 32'h8000_0000);
    wr(AC, ctrl_word(10'd8, 1'b0, 1'b1));
    ticks(4);
    rd_chk(AL, "R3 cnt lo after 4 ticks");
    chk("R3 expected 16", {32'd0, rdata}, 64'd16);
    rd_chk(AA, "R3 accum");

    // R5: idle cycles hold
    repeat (5) @(negedge clk);
    rd_chk(AL, "R5 cnt held");
    // R11: rdata holds while no read
    last = rdata;
    repeat (3) @(negedge clk);
    chk("R11 rdata held", {32'd0, rdata}, {32'd0, last});

    // R9: new trim used on next tick
    wr(AT, 32'h0000_0001);
    ticks(1);
    rd_chk(AA, "R9 accum after trim change");

    // R4: bypass
    wr(AC, ctrl_word(10'd25, 1'b1, 1'b1));
    ticks(3);
    rd_chk(AL, "R4 cnt lo bypass");
    rd_chk(AA, "R4 accum unchanged");

    // R7: paired write
    wr(AL, 32'hDEAD_BEEF);
    rd_chk(AL, "R7 cnt unchanged after lo write");
    step(1, 1, 0, AH, 32'h0000_1234);
    rd_chk(AL, "R7 loaded lo");
    rd_chk(AH, "R7 loaded hi");
    chk("R7 loaded hi value", {32'd0, rdata}, 64'h1234);
    ticks(1);
    rd_chk(AL, "R7 tick after load");

    // R10: wrap
    wr(AL, 32'hFFFF_FFFC);
    wr(AH, 32'hFFFF_FFFF);
    wr(AC, ctrl_word(10'd8, 1'b1, 1'b1));
    ticks(1);
    rd_chk(AL, "R10 wrap lo");
    rd_chk(AH, "R10 wrap hi");
    chk("R10 wrap value", m_cnt, 64'd4);

    // R6: shadow across a carry into the high word
    wr(AL, 32'hFFFF_FFF0);
    wr(AH, 32'h0000_0001);
    wr(AC, ctrl_word(10'd32, 1'b1, 1'b1));
    rd_chk(AL, "R6 lo sample");
    ticks(1);
    rd_chk(AH, "R6 hi from shadow");
    chk("R6 shadow keeps old hi", {32'd0, rdata}, 64'd1);
    rd_chk(AL, "R6 new lo");
    rd_chk(AH, "R6 new hi");

    // R8: soft reset
    wr(AT, 32'h3000_0000);
    wr(AC, ctrl_word(10'd7, 1'b0, 1'b1));
    ticks(5);
    wr(AL, 32'h1111_2222);
    wr(AC, ctrl_word(10'd9, 1'b0, 1'b1) | 32'h20);
    rd_chk(AC, "R8 ctrl kept, bit5 zero");
    rd_chk(AA, "R8 accum cleared");
    rd_chk(AH, "R8 shadow cleared");
    rd_chk(AL, "R8 cnt cleared");
    wr(AH, 32'h0000_0005);
    rd_chk(AL, "R8 hold cleared");

    // random phase
    for (int i = 0; i < 600; i++) begin
      r = $urandom;
      case (r[3:0])
        4'd8:  wr(AT, $urandom);
        4'd9:  begin
          r = $urandom;
          wr(AC, ctrl_word(r[9:0], r[12:10] == 3'd0, r[15:13] != 3'd0));
        end
        4'd10: begin rd_chk(AL, "R3 random lo"); rd_chk(AH, "R6 random hi"); end
        4'd11: wr(AL, $urandom);
        4'd12: begin r = $urandom; wr(AH, {28'd0, r[3:0]}); end
        4'd13: rd_chk(AA, "R9 random accum");
        4'd14: begin
          rd_chk(AL, "R6 random lo before tick");
          ticks(2);
          rd_chk(AH, "R6 random shadow after tick");
        end
        4'd15: begin @(negedge clk); idle_inputs(); end
        default: ticks(1);
      endcase
    end
    rd_chk(AL, "R3 final lo");
    rd_chk(AH, "R3 final hi");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule